// File: doc/BRIEF.md
# Pulse Accumulator with Timer Clock Steering

This block counts activity on a single input pin in a 16-bit accumulator. In edge mode it counts transitions of one chosen polarity. In gated mode it measures how long the pin sits at a chosen level: it counts a divide-by-64 tick from the timer prescaler while the pin is at that level. The pin is asynchronous and passes through a two-flop synchroniser before any edge or level is decoded.

The same block chooses the clock enable that drives a separate main timer counter. The choices are the prescaler tick, the accumulator's own count event, a carry out of the low count byte (every 256 events), or the full-count wrap (every 65536 events). Software controls the block through a small register interface with three registers: control, count and flags. The flags record an overflow and an input event. Software clears them either by writing 1s to the flag register or, in fast-clear mode, by any access to the count register.

All ticks are one-cycle enable pulses in the single `clk` domain. Reads are combinational on `bus_addr`, and `bus_rd` marks a read access for fast-clear.

Top module: `pulse_accum_top`

## Requirements
- R1: In edge mode (control bit 1 = 0), the count advances once per synchronised pin edge: a falling edge when the polarity bit (control bit 2) is 0, a rising edge when it is 1.
- R2: In gated mode (control bit 1 = 1), the count advances on each `div64_tick` that arrives while the synchronised pin is high (polarity 0) or low (polarity 1).
- R3: Nothing advances the count while the accumulator enable (control bit 0) is 0. In gated mode the count does not advance while `tmr_en` is 0.
- R4: Clock select (control bits 5:4) drives `tmr_clk_tick` from the following sources: 00 the prescaler tick, 01 the count event, 10 the low-byte carry, 11 the full wrap. When the accumulator enable is 0, the prescaler tick is used whatever the select holds. A new select applies from the cycle after the write.
- R5: The low-byte carry pulses when the count increments from xxFF. The full wrap pulses when the count increments from 0xFFFF.
- R6: The count register (address 1) reads and writes all 16 bits. It wraps from 0xFFFF to 0x0000. A write in the same cycle as an increment takes precedence.
- R7: The flag register (address 2) has the overflow flag at bit 1, set on a wrap, and the input flag at bit 0. The input flag is set on each counted edge in edge mode, and on the trailing edge of the active level in gated mode. A set in the same cycle as a clear wins.
- R8: Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. Bits 15:2 of the flag register read 0.
- R9: With fast-clear (control bit 7) set, any read or write of the count register clears both flags. With fast-clear at 0, reading the count leaves the flags alone.
- R10: No flag clears unless `tmr_en` or the accumulator enable is 1.
- R11: After reset, the control, count and flag registers read 0.
- R12: The control register (address 0) reads back its fields in the bit positions given above, with the other bits at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 1 | Asynchronous accumulator pin |
| tmr_en | input | 1 | Main timer enable; required for the divide-by-64 tick |
| presc_tick | input | 1 | Prescaler clock enable pulse |
| div64_tick | input | 1 | Prescaler divide-by-64 enable pulse |
| bus_addr | input | 2 | Register address: 0 control, 1 count, 2 flags |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read access marker (used for fast-clear) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| tmr_clk_tick | output | 1 | Selected clock enable for the main timer counter |
| ovf_flag | output | 1 | Overflow flag |
| inp_flag | output | 1 | Input event flag |

## Verification
The bench runs both edge polarities and both gated levels from each starting pin level. A design that swaps the polarity or the active level shows a count that differs from the number of matching transitions or held steps. It also exposes an input flag that fires on the leading edge of the gate instead of the trailing one. Counts preset just below 0x0100 and 0xFFFF show whether the divide-by-256 and divide-by-65536 steering, and the overflow flag, fire exactly once. A design that ignored the enable override would pass a carry instead of the prescaler tick. Flag-clearing tests cover several cases: a write of 0, a partial write of 1s, a count read with fast-clear both off and on, and clearing with both enables low. Each shows whether a flag is lost or kept when it should not be.

// File: rtl/pa_pkg.sv
// Package: shared types and register addresses for the pulse accumulator.
// Assumes a 2-bit register address space and 16-bit data.
package pa_pkg;
    typedef enum logic [1:0] {
        CS_PRESC    = 2'b00,
        CS_ACC      = 2'b01,
        CS_DIV_LOW  = 2'b10,
        CS_DIV_FULL = 2'b11
    } clk_sel_e;

    typedef struct packed {
        logic     fast_clr;
        clk_sel_e clk_sel;
        logic     edge_pol;
        logic     gated;
        logic     acc_on;
    } ctrl_t;

    localparam logic [1:0] A_CTRL  = 2'd0;
    localparam logic [1:0] A_COUNT = 2'd1;
    localparam logic [1:0] A_FLAGS = 2'd2;
endpackage

// File: rtl/pa_pin_sync.sv
// Module: synchronises the asynchronous pin and reports its level and edges.
// Assumes STAGES >= 2. Edges are one-cycle pulses taken after the last stage.
module pa_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic pin_lvl,
    output logic rise,
    output logic fall
);
    localparam int LAST = STAGES - 1;

    logic [STAGES:0] sr;

    // Shift the pin through the synchroniser plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[LAST:0], pin_in};
    end

    // Decode level and edges from the last two stages.
    always_comb begin
        pin_lvl = sr[LAST];
        rise    = sr[LAST] & ~sr[STAGES];
        fall    = ~sr[LAST] & sr[STAGES];
    end

    assert_edge_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    assert_edge_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall));
endmodule

// File: rtl/pa_event_sel.sv
// Module: turns pin edges/level and the divide-by-64 tick into count and
// input-flag events according to mode, polarity and enables. Pure logic.
module pa_event_sel (
    input  logic acc_on,
    input  logic gated,
    input  logic edge_pol,
    input  logic tmr_en,
    input  logic div64_tick,
    input  logic pin_lvl,
    input  logic rise,
    input  logic fall,
    output logic cnt_evt,
    output logic inp_evt
);
    logic sel_edge;
    logic active_lvl;

    // Select counting event and input-flag event for the current mode.
    always_comb begin
        // Edge mode counts the chosen edge; in gated mode the same edge is the
        // trailing edge of the active level (high for 0, low for 1).
        sel_edge   = edge_pol ? rise : fall;
        active_lvl = edge_pol ? ~pin_lvl : pin_lvl;
        if (gated) cnt_evt = acc_on & tmr_en & div64_tick & active_lvl;
        else       cnt_evt = acc_on & sel_edge;
        inp_evt = acc_on & sel_edge;
    end
endmodule

// File: rtl/pa_counter.sv
// Module: the accumulator count register with write port and carry pulses.
// Assumes LOW_W < CNT_W. A register write overrides an increment.
module pa_counter #(
    parameter int CNT_W = 16,
    parameter int LOW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic             low_carry,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic adv;

    // Qualify increments and derive the carry pulses from the current value.
    always_comb begin
        adv       = inc & ~wr_en;
        low_carry = adv & (&count[LOW_W-1:0]);
        wrap      = adv & (&count);
    end

    // Update the count: reset, write, or increment.
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (wr_en) count <= wr_data;
        else if (inc)   count <= count + ONE;
    end

    assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == '0));
    assert_write_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (count == $past(wr_data)));
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !wr_en) |=> $stable(count));
    assert_carry_with_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> low_carry);
endmodule

// File: rtl/pa_flags.sv
// Module: overflow and input flags with set-over-clear priority and a
// clear permission. Assumes clr_mask bit 1 = overflow, bit 0 = input.
module pa_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ovf_set,
    input  logic       inp_set,
    input  logic       clr_allowed,
    input  logic [1:0] clr_mask,
    output logic       ovf,
    output logic       inp
);
    logic [1:0] eff_clr;

    // Gate clear requests by the enable permission.
    always_comb eff_clr = clr_allowed ? clr_mask : 2'b00;

    // Hold, set or clear each flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
            inp <= 1'b0;
        end else begin
            ovf <= ovf_set | (ovf & ~eff_clr[1]);
            inp <= inp_set | (inp & ~eff_clr[0]);
        end
    end

    assert_ovf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> ovf);
    assert_inp_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        inp_set |=> inp);
    assert_clear_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_allowed |=> (!$fell(ovf) && !$fell(inp)));
endmodule

// File: rtl/pa_clk_sel.sv
// Module: chooses the main timer clock enable. Pure logic; a select change
// applies as soon as the control register holds it.
module pa_clk_sel
    import pa_pkg::*;
(
    input  logic     acc_on,
    input  clk_sel_e clk_sel,
    input  logic     presc_tick,
    input  logic     acc_tick,
    input  logic     low_tick,
    input  logic     full_tick,
    output logic     tmr_tick
);
    logic [3:0] src;

    // Index the four sources by select code, forced to prescaler when off.
    always_comb begin
        src      = {full_tick, low_tick, acc_tick, presc_tick};
        tmr_tick = acc_on ? src[clk_sel] : presc_tick;
    end
endmodule

// File: rtl/pulse_accum_top.sv
// Module: pulse accumulator top. Holds the control register, decodes the
// register interface and connects synchroniser, event logic, counter, flags
// and clock select. Assumes CNT_W >= 8 so control fields fit the data bus.
module pulse_accum_top
    import pa_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int LOW_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic             tmr_en,
    input  logic             presc_tick,
    input  logic             div64_tick,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             tmr_clk_tick,
    output logic             ovf_flag,
    output logic             inp_flag
);
    ctrl_t            ctrl;
    logic             pin_lvl, rise, fall;
    logic             cnt_evt, inp_evt;
    logic [CNT_W-1:0] count;
    logic             low_carry, wrap;
    logic             cnt_wr, cnt_access;
    logic [1:0]       clr_mask;
    logic [CNT_W-1:0] ctrl_word;

    // Capture control register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl <= '0;
        else if (bus_wr && bus_addr == A_CTRL) begin
            ctrl.fast_clr <= bus_wdata[7];
            ctrl.clk_sel  <= clk_sel_e'(bus_wdata[5:4]);
            ctrl.edge_pol <= bus_wdata[2];
            ctrl.gated    <= bus_wdata[1];
            ctrl.acc_on   <= bus_wdata[0];
        end
    end

    // Decode count access and flag clear requests.
    always_comb begin
        cnt_wr     = bus_wr & (bus_addr == A_COUNT);
        cnt_access = (bus_wr | bus_rd) & (bus_addr == A_COUNT);
        clr_mask   = 2'b00;
        if (bus_wr && bus_addr == A_FLAGS) clr_mask = bus_wdata[1:0];
        if (ctrl.fast_clr && cnt_access)   clr_mask = 2'b11;
    end

    // Form the read view of the control register.
    always_comb begin
        ctrl_word      = '0;
        ctrl_word[0]   = ctrl.acc_on;
        ctrl_word[1]   = ctrl.gated;
        ctrl_word[2]   = ctrl.edge_pol;
        ctrl_word[5:4] = ctrl.clk_sel;
        ctrl_word[7]   = ctrl.fast_clr;
    end

    // Combinational read mux.
    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_word;
            A_COUNT: bus_rdata = count;
            A_FLAGS: bus_rdata = {{(CNT_W-2){1'b0}}, ovf_flag, inp_flag};
            default: bus_rdata = '0;
        endcase
    end

    pa_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .pin_lvl(pin_lvl), .rise(rise), .fall(fall)
    );

    pa_event_sel u_evt (
        .acc_on(ctrl.acc_on), .gated(ctrl.gated), .edge_pol(ctrl.edge_pol),
        .tmr_en(tmr_en), .div64_tick(div64_tick), .pin_lvl(pin_lvl),
        .rise(rise), .fall(fall), .cnt_evt(cnt_evt), .inp_evt(inp_evt)
    );

    pa_counter #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(cnt_evt), .wr_en(cnt_wr),
        .wr_data(bus_wdata), .count(count), .low_carry(low_carry), .wrap(wrap)
    );

    pa_flags u_flags (
        .clk(clk), .rst_n(rst_n), .ovf_set(wrap), .inp_set(inp_evt),
        .clr_allowed(tmr_en | ctrl.acc_on), .clr_mask(clr_mask),
        .ovf(ovf_flag), .inp(inp_flag)
    );

    pa_clk_sel u_csel (
        .acc_on(ctrl.acc_on), .clk_sel(ctrl.clk_sel), .presc_tick(presc_tick),
        .acc_tick(cnt_evt), .low_tick(low_carry), .full_tick(wrap),
        .tmr_tick(tmr_clk_tick)
    );

    assert_disabled_no_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.acc_on && !cnt_wr) |=> $stable(count));
    assert_gate_needs_timer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.gated && !tmr_en && !cnt_wr) |=> $stable(count));
    assert_fast_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.fast_clr && cnt_access && (tmr_en || ctrl.acc_on) && !wrap && !inp_evt)
        |=> (!ovf_flag && !inp_flag));
endmodule

// File: tb/pulse_accum_top_bench.sv
module pulse_accum_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0;
    logic        tmr_en = 1'b0;
    logic        presc_tick = 1'b0;
    logic        div64_tick = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        tmr_clk_tick, ovf_flag, inp_flag;

    int checks = 0;
    int errors = 0;
    int tick_cnt = 0;
    logic tick_clr = 1'b0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    pulse_accum_top u_pulse_accum_top (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .tmr_en(tmr_en),
        .presc_tick(presc_tick), .div64_tick(div64_tick),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmr_clk_tick(tmr_clk_tick), .ovf_flag(ovf_flag), .inp_flag(inp_flag)
    );

    // Count timer clock pulses, sampled just after each rising edge.
    initial forever begin
        @(posedge clk);
        #3;
        if (tick_clr) tick_cnt = 0;
        else if (tmr_clk_tick) tick_cnt++;
    end

    typedef struct packed {
        logic        gated;
        logic        pol;
        logic        ten;
        logic        start;
        logic [7:0]  pat;
        logic [15:0] exp_cnt;
        logic        exp_inp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'h55, 16'd4, 1'b1},
        '{1'b0, 1'b1, 1'b1, 1'b0, 8'h55, 16'd4, 1'b1},
        '{1'b0, 1'b1, 1'b1, 1'b0, 8'h07, 16'd1, 1'b1},
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'h07, 16'd1, 1'b1},
        '{1'b1, 1'b0, 1'b1, 1'b0, 8'h07, 16'd3, 1'b1},
        '{1'b1, 1'b1, 1'b1, 1'b0, 8'h07, 16'd5, 1'b1},
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'h07, 16'd0, 1'b1},
        '{1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, 16'd0, 1'b0},
        '{1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 16'd8, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_ticks();
        @(negedge clk);
        tick_clr = 1'b1;
        @(negedge clk);
        tick_clr = 1'b0;
    endtask

    task automatic pulse_presc();
        @(negedge clk);
        presc_tick = 1'b1;
        @(negedge clk);
        presc_tick = 1'b0;
    endtask

    task automatic rise_edge();
        @(negedge clk);
        pin_in = 1'b1;
        idle(4);
        pin_in = 1'b0;
        idle(4);
    endtask

    // ctrl word: bit0 enable, bit1 gated, bit2 polarity, bits5:4 select, bit7 fast clear
    function automatic logic [15:0] cw(input logic fc, input logic [1:0] sel,
                                       input logic pol, input logic g, input logic en);
        return {8'h00, fc, 1'b0, sel, 1'b0, pol, g, en};
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog all-R actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R11: reset state; R4: disabled accumulator passes prescaler (idle 0)
        bus_read(2'd0, rd); check("R11 ctrl", rd, 16'h0000);
        bus_read(2'd1, rd); check("R11 count", rd, 16'h0000);
        bus_read(2'd2, rd); check("R11 flags", rd, 16'h0000);
        check("R4 idle tick", tmr_clk_tick, 1'b0);

        // R12: control read-back positions
        bus_write(2'd0, 16'hFFFE);
        bus_read(2'd0, rd); check("R12 ctrl fields", rd, 16'h00B6);
        bus_write(2'd0, 16'h0000);

        // Vector table: R1, R2, R3, R4 (select 01), R7 input flag
        for (int i = 0; i < NV; i++) begin
            tmr_en = 1'b1;
            bus_write(2'd0, cw(1'b0, 2'b01, VECS[i].pol, VECS[i].gated, 1'b0));
            @(negedge clk); pin_in = VECS[i].start;
            idle(4);
            bus_write(2'd1, 16'h0000);
            bus_write(2'd2, 16'h0003);
            tmr_en = VECS[i].ten;
            clear_ticks();
            bus_write(2'd0, cw(1'b0, 2'b01, VECS[i].pol, VECS[i].gated, 1'b1));
            for (int s = 0; s < 8; s++) begin
                @(negedge clk); pin_in = VECS[i].pat[s];
                idle(2);
                @(negedge clk); div64_tick = 1'b1;
                @(negedge clk); div64_tick = 1'b0;
            end
            idle(3);
            bus_read(2'd1, rd);
            check(VECS[i].gated ? "R2 gated count" : "R1 edge count", rd, VECS[i].exp_cnt);
            check("R4 acc tick", tick_cnt, VECS[i].exp_cnt);
            bus_read(2'd2, rd);
            check("R7 input flag", rd, {15'd0, VECS[i].exp_inp});
        end
        tmr_en = 1'b1;

        // R3/R4: enable off forces prescaler tick, edges not counted
        bus_write(2'd0, cw(1'b0, 2'b11, 1'b1, 1'b0, 1'b0));
        bus_write(2'd1, 16'h0000);
        clear_ticks();
        repeat (3) pulse_presc();
        rise_edge(); rise_edge();
        check("R4 forced prescaler", tick_cnt, 3);
        bus_read(2'd1, rd); check("R3 disabled count", rd, 16'h0000);

        // R4: select 00 effective right after write
        bus_write(2'd0, cw(1'b0, 2'b00, 1'b1, 1'b0, 1'b1));
        clear_ticks();
        pulse_presc(); pulse_presc();
        check("R4 select prescaler", tick_cnt, 2);

        // R5: low-byte carry on select 10
        bus_write(2'd0, cw(1'b0, 2'b10, 1'b1, 1'b0, 1'b1));
        bus_write(2'd1, 16'h00FE);
        bus_write(2'd2, 16'h0003);
        clear_ticks();
        repeat (3) rise_edge();
        bus_read(2'd1, rd); check("R6 count after carry", rd, 16'h0101);
        check("R5 low carry ticks", tick_cnt, 1);
        bus_read(2'd2, rd); check("R7 no overflow", rd, 16'h0001);

        // R5/R6/R7: full wrap on select 11
        bus_write(2'd0, cw(1'b0, 2'b11, 1'b1, 1'b0, 1'b1));
        bus_write(2'd1, 16'hFFFE);
        bus_write(2'd2, 16'h0003);
        clear_ticks();
        repeat (3) rise_edge();
        bus_read(2'd1, rd); check("R6 wrap count", rd, 16'h0001);
        check("R5 wrap ticks", tick_cnt, 1);
        bus_read(2'd2, rd); check("R7 overflow set", rd, 16'h0003);

        // R8: write-1-to-clear, write 0 no effect
        bus_write(2'd2, 16'h0000);
        bus_read(2'd2, rd); check("R8 write zero", rd, 16'h0003);
        bus_write(2'd2, 16'hFFFD);
        bus_read(2'd2, rd); check("R8 clear input only", rd, 16'h0002);
        bus_write(2'd2, 16'h0002);
        bus_read(2'd2, rd); check("R8 clear overflow", rd, 16'h0000);

        // R9: count read without fast clear keeps flags
        bus_write(2'd1, 16'hFFFF);
        rise_edge();
        bus_read(2'd1, rd);
        bus_read(2'd2, rd); check("R9 no fast clear", rd, 16'h0003);
        // R9: fast clear by read
        bus_write(2'd0, cw(1'b1, 2'b01, 1'b1, 1'b0, 1'b1));
        bus_read(2'd1, rd);
        bus_read(2'd2, rd); check("R9 fast clear read", rd, 16'h0000);
        // R9: fast clear by write
        bus_write(2'd1, 16'hFFFF);
        rise_edge();
        bus_read(2'd2, rd); check("R9 flags set again", rd, 16'h0003);
        bus_write(2'd1, 16'h1234);
        bus_read(2'd2, rd); check("R9 fast clear write", rd, 16'h0000);
        bus_read(2'd1, rd); check("R6 write value", rd, 16'h1234);

        // R10: clear blocked with both enables off
        bus_write(2'd0, cw(1'b0, 2'b01, 1'b1, 1'b0, 1'b1));
        bus_write(2'd1, 16'hFFFF);
        rise_edge();
        bus_write(2'd0, cw(1'b0, 2'b01, 1'b1, 1'b0, 1'b0));
        tmr_en = 1'b0;
        bus_write(2'd2, 16'h0003);
        bus_read(2'd2, rd); check("R10 clear blocked", rd, 16'h0003);
        tmr_en = 1'b1;
        bus_write(2'd2, 16'h0003);
        bus_read(2'd2, rd); check("R10 clear allowed", rd, 16'h0000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule